// File: doc/BRIEF.md
# Symbol-Sequence Combination Lock

This block is a lock controller that runs on a fast system clock but behaves, from the user's side, like a level-driven asynchronous lock. A 2-bit symbol comes in from free-running user switches. Each bit passes through its own synchronizer chain. A stability filter then accepts a new symbol only once the whole word has held one value for a set number of consecutive clocks. Because of this, skew between the two switch bits cannot create a symbol that the user never selected.

A sequence controller advances on each accepted change of symbol. A symbol held at the switches does not advance it again, so the secret combination can never repeat a symbol back to back. The combination is fixed at compile time and is checked during elaboration. Once the last symbol of the combination is entered correctly, the lock opens and stays open. It closes again only when the reset is applied. The reset takes effect at once, without a clock, and is released in step with the clock.

Top module: `combo_lock`

## Requirements
- R1: While `rst_n` is low, `unlocked_o` is 0 and `progress_o` is 0. Both take effect as soon as `rst_n` falls, with no clock edge needed, so a reset in the middle of a sequence relocks the block and discards the entry made so far.
- R2: A value at `sym_i` is accepted only after the synchronized word has held it for STABLE_CYCLES consecutive clocks (default 4). A shorter excursion is ignored and has no effect on `progress_o`. This includes the intermediate word seen while one bit has changed and the other has not yet.
- R3: While the accepted symbol stays the same, `progress_o` does not change, however long the symbol is held.
- R4: `progress_o` gives the number of correct symbols entered so far, from 0 to 4. Combination symbol k sits at bits [2k+1:2k] of COMBO, and symbol 0 is entered first. The default COMBO is 8'h36, which gives the order 2, 1, 3, 0. When a newly accepted symbol equals combination symbol `progress_o`, progress increases by one.
- R5: A newly accepted symbol that does not match the expected one sets `progress_o` to 1 if it equals combination symbol 0. Otherwise it sets `progress_o` to 0.
- R6: After the fourth correct symbol, `unlocked_o` is 1 and `progress_o` is 4. Both stay that way through any later symbol changes until reset.
- R7: The symbol present when reset is released becomes the current symbol and is not counted as an entry. Only a later change can start or advance a sequence.
- R8: A COMBO in which two adjacent symbols are equal is rejected during elaboration. The same applies to STABLE_CYCLES below 2 and to fewer than 2 synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low reset; takes effect at once, released in step with the clock |
| sym_i | input | 2 | Symbol from the user switches, not synchronized to the clock |
| unlocked_o | output | 1 | High once the full combination has been entered |
| progress_o | output | 3 | Number of correct symbols entered so far (0 to 4) |

## Verification
The assertions assume that `sym_i` stays at each value the user means to enter far longer than the synchronizer delay plus STABLE_CYCLES. They also assume that any shorter excursion is a glitch that should leave no trace. On that basis they hold that progress moves only on an accepted-symbol pulse, and that an open lock stays open. The stimulus holds every intended symbol for at least twelve clocks. It also applies deliberate two-clock skew windows between the bits and short single-value glitches. Both of these stay well inside the filter window, so that the rejection path is exercised and the assumption is never broken.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
   localparam int unsigned SYM_W   = 2;
   localparam int unsigned SEQ_LEN = 4;
   typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/cl_reset_sync.sv
module cl_reset_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n_i,
   output logic rst_n_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cl_bit_sync.sv
module cl_bit_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff_q <= '0;
         else        ff_q <= {ff_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = ff_q[STAGES-1];
   end
endmodule

// File: rtl/cl_sym_filter.sv
module cl_sym_filter #(
   parameter int unsigned WIDTH         = 2,
   parameter int unsigned STABLE_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] s_i,
   output logic             new_o,
   output logic [WIDTH-1:0] sym_o
);
   localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);
   localparam logic [CW-1:0] FULL = CW'(STABLE_CYCLES);

   logic [WIDTH-1:0] cand_q, cur_q;
   logic [CW-1:0]    cnt_q;
   logic             primed_q;
   logic             settle;

   // this sample completes the run of identical samples
   assign settle = (s_i == cand_q) && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q   <= '0;
         cnt_q    <= '0;
         cur_q    <= '0;
         primed_q <= 1'b0;
         new_o    <= 1'b0;
      end else begin
         new_o <= 1'b0;
         if (s_i != cand_q) begin
            cand_q <= s_i;
            cnt_q  <= CW'(1);
         end else if (cnt_q != FULL) begin
            cnt_q <= cnt_q + CW'(1);
         end
         if (settle) begin
            if (!primed_q) begin
               primed_q <= 1'b1;
               cur_q    <= cand_q;
            end else if (cand_q != cur_q) begin
               cur_q <= cand_q;
               new_o <= 1'b1;
            end
         end
      end
   end

   assign sym_o = cur_q;
endmodule

// File: rtl/cl_seq_fsm.sv
module cl_seq_fsm
   import combo_lock_pkg::*;
#(
   parameter logic [SEQ_LEN*SYM_W-1:0] COMBO = 8'h36
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         new_i,
   input  sym_t                         sym_i,
   output logic                         unlocked_o,
   output logic [$clog2(SEQ_LEN+1)-1:0] progress_o
);
   localparam int unsigned PW = $clog2(SEQ_LEN + 1);
   localparam logic [PW-1:0] DONE = PW'(SEQ_LEN);

   logic [PW-1:0] prog_q, prog_d;
   logic          open_q;
   sym_t          expect_sym;

   always_comb begin
      expect_sym = COMBO[0 +: SYM_W];
      for (int k = 0; k < SEQ_LEN; k++)
         if (prog_q == PW'(k)) expect_sym = COMBO[k*SYM_W +: SYM_W];
   end

   always_comb begin
      prog_d = prog_q;
      if (new_i && !open_q) begin
         if (sym_i == expect_sym)                 prog_d = prog_q + PW'(1);
         else if (sym_i == COMBO[0 +: SYM_W])     prog_d = PW'(1);
         else                                     prog_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q <= '0;
         open_q <= 1'b0;
      end else begin
         prog_q <= prog_d;
         if (prog_d == DONE) open_q <= 1'b1;
      end
   end

   assign progress_o = prog_q;
   assign unlocked_o = open_q;
endmodule

// File: rtl/combo_lock.sv
module combo_lock
   import combo_lock_pkg::*;
#(
   parameter logic [SEQ_LEN*SYM_W-1:0] COMBO         = 8'h36,
   parameter int unsigned              SYNC_STAGES   = 2,
   parameter int unsigned              STABLE_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sym_i,
   output logic       unlocked_o,
   output logic [2:0] progress_o
);
   // R8: parameter checks at elaboration
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("combo_lock: SYNC_STAGES must be at least 2");
   end
   if (STABLE_CYCLES < 2) begin : g_bad_stable
      $error("combo_lock: STABLE_CYCLES must be at least 2");
   end
   for (genvar k = 1; k < SEQ_LEN; k++) begin : g_adj
      if (COMBO[k*SYM_W +: SYM_W] == COMBO[(k-1)*SYM_W +: SYM_W]) begin : g_rep
         $error("combo_lock: adjacent combination symbols must differ");
      end
   end

   logic rst_n_sync;
   sym_t sym_sync, acc_sym;
   logic new_sym;

   cl_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_sync)
   );

   cl_bit_sync #(.WIDTH(SYM_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n_sync), .d_i(sym_i), .q_o(sym_sync)
   );

   cl_sym_filter #(.WIDTH(SYM_W), .STABLE_CYCLES(STABLE_CYCLES)) u_filt (
      .clk(clk), .rst_n(rst_n_sync), .s_i(sym_sync),
      .new_o(new_sym), .sym_o(acc_sym)
   );

   cl_seq_fsm #(.COMBO(COMBO)) u_fsm (
      .clk(clk), .rst_n(rst_n_sync), .new_i(new_sym), .sym_i(acc_sym),
      .unlocked_o(unlocked_o), .progress_o(progress_o)
   );
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
   import combo_lock_pkg::*;
#(
   parameter logic [SEQ_LEN*SYM_W-1:0] COMBO = 8'h36
) (
   input logic       clk,
   input logic       rst_n,
   input logic       new_sym,
   input sym_t       acc_sym,
   input logic       unlocked,
   input logic [2:0] progress
);
   AST_PROGRESS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      progress <= 3'(SEQ_LEN)); // R4
   AST_HOLD_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      !new_sym |=> $stable(progress)); // R3
   AST_STEP_OR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (new_sym && !unlocked) |=> (progress == $past(progress) + 3'd1) || (progress <= 3'd1)); // R5
   AST_WRONG_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (new_sym && !unlocked && progress == 3'd0 && acc_sym != COMBO[1:0]) |=> progress == 3'd0); // R5
   AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked |=> unlocked && progress == 3'(SEQ_LEN)); // R6
   AST_UNLOCK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(new_sym)); // R6
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      new_sym |=> !new_sym); // R2
endmodule

bind combo_lock combo_lock_chk #(.COMBO(COMBO)) u_chk (
   .clk(clk), .rst_n(rst_n_sync), .new_sym(new_sym), .acc_sym(acc_sym),
   .unlocked(unlocked_o), .progress(progress_o)
);

// File: tb/tb_combo_lock.sv
`timescale 1ns/1ps
module tb_combo_lock;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sym = 2'd0;
   logic       unlocked;
   logic [2:0] progress;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;

   always #2 clk = ~clk; // 250 MHz

   combo_lock dut (
      .clk(clk), .rst_n(rst_n), .sym_i(sym),
      .unlocked_o(unlocked), .progress_o(progress)
   );

   task automatic check(input string req, input logic exp_u, input logic [2:0] exp_p);
      n_chk++;
      if (unlocked !== exp_u || progress !== exp_p) begin
         n_bad++;
         $display("FAIL %s: unlocked=%0b progress=%0d expected unlocked=%0b progress=%0d",
                  req, unlocked, progress, exp_u, exp_p);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic enter(input logic [1:0] s);
      @(negedge clk);
      sym = s;
      wait_cyc(14);
   endtask

   task automatic do_reset(input logic [1:0] s);
      @(negedge clk);
      rst_n = 1'b0;
      sym = s;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(14);
   endtask

   // R1 R7: reset state, symbol at release is not an entry
   task automatic t_reset_release;
      do_reset(2'd2);
      check("R1", 1'b0, 3'd0);
      check("R7", 1'b0, 3'd0);
   endtask

   // R4 R6: correct sequence 2,1,3,0 (R8: default combination elaborates)
   task automatic t_unlock;
      do_reset(2'd0);
      enter(2'd2); check("R4", 1'b0, 3'd1);
      enter(2'd1); check("R4", 1'b0, 3'd2);
      enter(2'd3); check("R4", 1'b0, 3'd3);
      enter(2'd0); check("R6", 1'b1, 3'd4);
      enter(2'd1); check("R6", 1'b1, 3'd4);
      enter(2'd2); check("R6", 1'b1, 3'd4);
   endtask

   // R3: holding a symbol does not advance
   task automatic t_hold;
      do_reset(2'd0);
      enter(2'd2);
      wait_cyc(60);
      check("R3", 1'b0, 3'd1);
   endtask

   // R5: wrong symbol restarts; first symbol counts as step one
   task automatic t_wrong;
      do_reset(2'd0);
      enter(2'd2); enter(2'd1);
      enter(2'd0); check("R5", 1'b0, 3'd0);
      enter(2'd2); enter(2'd1);
      enter(2'd2); check("R5", 1'b0, 3'd1);
   endtask

   // R2: bit skew and short glitches produce no symbol
   task automatic t_skew;
      do_reset(2'd0);
      enter(2'd2);
      @(negedge clk); sym = 2'b00;   // bit 1 falls first
      wait_cyc(2);
      sym = 2'b01;                   // bit 0 follows
      wait_cyc(14);
      check("R2", 1'b0, 3'd2);
      @(negedge clk); sym = 2'b00;   // two-clock glitch to a wrong symbol
      wait_cyc(2);
      sym = 2'b01;
      wait_cyc(14);
      check("R2", 1'b0, 3'd2);
   endtask

   // R1: asynchronous reset mid-sequence and after unlock
   task automatic t_async_reset;
      do_reset(2'd0);
      enter(2'd2); enter(2'd1);
      @(negedge clk); #0.5 rst_n = 1'b0; #0.5;
      check("R1", 1'b0, 3'd0);
      wait_cyc(2); rst_n = 1'b1; wait_cyc(14);
      enter(2'd2); enter(2'd1); enter(2'd3); enter(2'd0);
      check("R6", 1'b1, 3'd4);
      @(negedge clk); #0.5 rst_n = 1'b0; #0.5;
      check("R1", 1'b0, 3'd0);
      wait_cyc(2); rst_n = 1'b1; wait_cyc(14);
      check("R1", 1'b0, 3'd0);
   endtask

   initial begin : watchdog
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset_release();
      t_unlock();
      t_hold();
      t_wrong();
      t_skew();
      t_async_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule